// File: doc/BRIEF.md
# Flash Read-Path SECDED Checker with Address Folding

This block sits on the read return path of an embedded flash. Each 128-bit beat arrives with its beat address and two check bytes. The beat is split into a lower and an upper 64-bit word, and two identical lanes check them at the same time. Each lane decodes an extended Hamming (72,64) code. The code is computed over the data word XORed with a fold of the word's own address, so data returned from the wrong location is caught. A single-bit error is corrected in the data that goes downstream. The stored contents are never rewritten.

Correctable events feed a saturating counter. When that counter reaches a programmable threshold, it raises a held interrupt. Uncorrectable words (two flipped bits, or one wrong address bit) raise a fatal flag. A 4-bit key register turns checking on and off. The first failing word is latched, with its beat address, lane and syndrome, until software clears it. Debug-port reads and words that are entirely erased (all ones) or entirely zero pass through untouched.

Top module: `flash_rd_secded`

## Requirements
- R1: `out_valid`, `out_data` and `fatal_err` are registered and appear one clock after `rd_valid`. After reset, `out_valid`, `fatal_err`, `ce_irq`, `ce_count` and `cap_valid` are all 0.
- R2: Lane 0 takes `rd_data[63:0]` with `rd_chk[7:0]`, and lane 1 takes `rd_data[127:64]` with `rd_chk[15:8]`. A lane's word address is `{rd_beat, lane}`. Word-address bit i is XORed into data bits i and i+32. Hamming positions 1..71 hold check bits `chk[k]` at position 2^k, and data bits 0..63 fill the other positions in ascending order. `chk[7]` is even parity over the 71 bits. A clean codeword leaves the block unchanged and raises no flag.
- R3: A single flipped bit anywhere in a lane's 72 bits is corrected in `out_data`, and that lane counts one correctable event.
- R4: Two flipped bits in a lane raise `fatal_err` together with `out_valid`. The data for that lane is passed through uncorrected.
- R5: A codeword presented at a word address that differs from its encoding address in one bit raises `fatal_err`.
- R6: A lane whose 72 raw bits are all ones or all zeros is not evaluated. Its data passes through raw and it raises no event.
- R7: Checking is active only while the enable register holds 4'hA, which is also its reset value. With any other value, beats pass through raw with no event.
- R8: A beat with `rd_debug` high passes through raw with no event, whatever the enable register holds.
- R9: `ce_count` adds one for each correctable lane, so up to two per beat. It saturates at its maximum. Writing bit 2 at select 2 clears it before that cycle's events are added.
- R10: The threshold resets to 1, and a write of 0 stores 1. On a cycle with a correctable event, `ce_irq` is set if the updated count is at least the threshold. It then stays high until bit 0 is written at select 2.
- R11: On the first correctable or uncorrectable event while no capture is held, the block latches the beat address, `cap_upper` (lane 0 has priority) and `cap_syn` = {overall parity mismatch, 7-bit Hamming syndrome}. Writing bit 1 at select 2 releases the capture, and an event in that same cycle is captured afresh.
- R12: Configuration writes use `cfg_sel`: 0 writes the enable key from `cfg_wdata[3:0]`, 1 writes the threshold, and 2 writes the clear bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_valid | input | 1 | Read beat present |
| rd_debug | input | 1 | Beat belongs to a debug read; bypass checking |
| rd_beat | input | BEAT_AW | Address of the 128-bit beat |
| rd_data | input | 128 | Raw beat data |
| rd_chk | input | 16 | Raw check bytes, lane 0 in the low byte |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Configuration register select |
| cfg_wdata | input | CNT_W | Configuration write data |
| out_valid | output | 1 | Checked beat valid |
| out_data | output | 128 | Corrected or raw beat data |
| fatal_err | output | 1 | Uncorrectable error in this beat |
| ce_irq | output | 1 | Correctable-error threshold interrupt, held |
| ce_count | output | CNT_W | Saturating correctable-event count |
| cap_valid | output | 1 | A failing word is latched |
| cap_beat | output | BEAT_AW | Beat address of the latched word |
| cap_upper | output | 1 | Latched word came from lane 1 |
| cap_syn | output | 8 | Latched syndrome |

## Verification
The pass-through assertions assume that `rd_data` is stable across the sampling edge and that debug beats and key changes arrive only as single-cycle events. The bench drives every input at the falling edge and holds it for one full period. The capture-hold property assumes that a clear is the only way to release the latch, and the stimulus never resets mid-run. Every injected error stays inside what the code is guaranteed to classify: at most two flipped bits per lane and exactly one wrong address bit. This keeps the bench's expected outcomes well defined.

// File: rtl/flash_ecc_pkg.sv
package flash_ecc_pkg;

    localparam int DATA_W = 64;
    localparam int HAM_W  = 7;
    localparam int CHK_W  = 8;

    // Hamming position of data bit idx: the idx-th position in 3..71 that is not a power of two.
    function automatic logic [HAM_W-1:0] ecc_data_pos(input int idx);
        int n;
        logic [HAM_W-1:0] p;
        n = 0;
        p = '0;
        for (int q = 3; q < 72; q++) begin
            if ((q & (q - 1)) != 0) begin
                if (n == idx) p = HAM_W'(q);
                n++;
            end
        end
        return p;
    endfunction

    // Address fold: word-address bit i lands on data bits i and i+32.
    function automatic logic [DATA_W-1:0] ecc_fold(input logic [31:0] wa);
        return {wa, wa};
    endfunction

    function automatic logic [HAM_W-1:0] ecc_parity(input logic [DATA_W-1:0] d);
        logic [HAM_W-1:0] p;
        logic [HAM_W-1:0] pos;
        p = '0;
        for (int j = 0; j < DATA_W; j++) begin
            pos = ecc_data_pos(j);
            for (int k = 0; k < HAM_W; k++) p[k] = p[k] ^ (pos[k] & d[j]);
        end
        return p;
    endfunction

    function automatic logic [CHK_W-1:0] ecc_encode(input logic [DATA_W-1:0] data,
                                                    input logic [31:0] wa);
        logic [DATA_W-1:0] d;
        logic [HAM_W-1:0]  p;
        d = data ^ ecc_fold(wa);
        p = ecc_parity(d);
        return {(^d) ^ (^p), p};
    endfunction

endpackage

// File: rtl/flash_ecc_lane.sv
module flash_ecc_lane import flash_ecc_pkg::*; #(
    parameter int WA_W = 21
) (
    input  logic [DATA_W-1:0] raw_data,
    input  logic [CHK_W-1:0]  raw_chk,
    input  logic [WA_W-1:0]   word_addr,
    output logic [DATA_W-1:0] fix_data,
    output logic              corr,
    output logic              uncorr,
    output logic [CHK_W-1:0]  syn
);

    logic [DATA_W-1:0] unfold;
    logic [DATA_W-1:0] flip;
    logic [HAM_W-1:0]  s;
    logic              odd;
    logic              skip;
    logic              on_pos;

    always_comb begin
        unfold = raw_data ^ ecc_fold(32'(word_addr));
        s      = ecc_parity(unfold) ^ raw_chk[HAM_W-1:0];
        odd    = (^unfold) ^ (^raw_chk);
        skip   = (&{raw_data, raw_chk}) || !(|{raw_data, raw_chk});
        flip   = '0;
        for (int j = 0; j < DATA_W; j++) flip[j] = (ecc_data_pos(j) == s);
        // an odd error maps to a real bit: a check bit, the parity bit, or a data bit
        on_pos   = ((s & (s - HAM_W'(1))) == '0) || (|flip);
        corr     = !skip && odd && on_pos;
        uncorr   = !skip && (odd ? !on_pos : (s != '0));
        fix_data = corr ? (raw_data ^ flip) : raw_data;
        syn      = {odd, s};
    end

endmodule

// File: rtl/flash_ce_tracker.sv
module flash_ce_tracker #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       hits,
    input  logic             thr_we,
    input  logic [CNT_W-1:0] thr_wdata,
    input  logic             clr_cnt,
    input  logic             clr_irq,
    output logic [CNT_W-1:0] count,
    output logic             irq
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] thr;
        logic             irq;
    } trk_t;

    trk_t           st_d, st_q;
    logic [CNT_W:0] sum;

    always_comb begin
        st_d = st_q;
        if (clr_cnt) st_d.cnt = '0;
        sum      = {1'b0, st_d.cnt} + (CNT_W+1)'(hits[0]) + (CNT_W+1)'(hits[1]);
        st_d.cnt = sum[CNT_W] ? CNT_MAX : sum[CNT_W-1:0];
        if (thr_we) st_d.thr = (thr_wdata == '0) ? CNT_W'(1) : thr_wdata;
        if (clr_irq) st_d.irq = 1'b0;
        if ((|hits) && (st_d.cnt >= st_q.thr)) st_d.irq = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt <= '0;
            st_q.thr <= CNT_W'(1);
            st_q.irq <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count = st_q.cnt;
    assign irq   = st_q.irq;

    AST_CNT_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt == CNT_MAX && !clr_cnt) |=> (st_q.cnt == CNT_MAX)); // R9
    AST_THR_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.thr != '0); // R10
    AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.irq) |-> $past(|hits)); // R10

endmodule

// File: rtl/flash_rd_secded.sv
module flash_rd_secded import flash_ecc_pkg::*; #(
    parameter int         BEAT_AW = 20,
    parameter int         CNT_W   = 8,
    parameter logic [3:0] EN_KEY  = 4'hA
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rd_valid,
    input  logic                 rd_debug,
    input  logic [BEAT_AW-1:0]   rd_beat,
    input  logic [127:0]         rd_data,
    input  logic [15:0]          rd_chk,
    input  logic                 cfg_we,
    input  logic [1:0]           cfg_sel,
    input  logic [CNT_W-1:0]     cfg_wdata,
    output logic                 out_valid,
    output logic [127:0]         out_data,
    output logic                 fatal_err,
    output logic                 ce_irq,
    output logic [CNT_W-1:0]     ce_count,
    output logic                 cap_valid,
    output logic [BEAT_AW-1:0]   cap_beat,
    output logic                 cap_upper,
    output logic [CHK_W-1:0]     cap_syn
);

    localparam int LANES  = 2;
    localparam int BEAT_W = LANES * DATA_W;
    localparam int WA_W   = BEAT_AW + 1;
    localparam int EN_W   = 4;

    typedef struct packed {
        logic               vld;
        logic [BEAT_W-1:0]  data;
        logic               fatal;
        logic [EN_W-1:0]    en;
        logic               cap_v;
        logic [BEAT_AW-1:0] cap_beat;
        logic               cap_up;
        logic [CHK_W-1:0]   cap_syn;
    } top_t;

    top_t st_d, st_q;

    logic [LANES-1:0][DATA_W-1:0] fix;
    logic [LANES-1:0][CHK_W-1:0]  l_syn;
    logic [LANES-1:0]             l_corr, l_unc, hit_c, hit_u;
    logic                         chk_on, en_we, thr_we, clr_w;
    logic                         clr_irq, clr_cap, clr_cnt;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        flash_ecc_lane #(.WA_W(WA_W)) u_lane (
            .raw_data  (rd_data[g*DATA_W +: DATA_W]),
            .raw_chk   (rd_chk[g*CHK_W +: CHK_W]),
            .word_addr ({rd_beat, (g == 1)}),
            .fix_data  (fix[g]),
            .corr      (l_corr[g]),
            .uncorr    (l_unc[g]),
            .syn       (l_syn[g])
        );
    end

    always_comb begin
        chk_on  = rd_valid && !rd_debug && (st_q.en == EN_KEY);
        hit_c   = chk_on ? l_corr : '0;
        hit_u   = chk_on ? l_unc  : '0;
        en_we   = cfg_we && (cfg_sel == 2'd0);
        thr_we  = cfg_we && (cfg_sel == 2'd1);
        clr_w   = cfg_we && (cfg_sel == 2'd2);
        clr_irq = clr_w && cfg_wdata[0];
        clr_cap = clr_w && cfg_wdata[1];
        clr_cnt = clr_w && cfg_wdata[2];

        st_d       = st_q;
        st_d.vld   = rd_valid;
        if (rd_valid) st_d.data = chk_on ? fix : rd_data;
        st_d.fatal = |hit_u;
        if (en_we) st_d.en = cfg_wdata[EN_W-1:0];
        if (clr_cap) st_d.cap_v = 1'b0;
        if (!st_d.cap_v && (|(hit_c | hit_u))) begin
            st_d.cap_v    = 1'b1;
            st_d.cap_beat = rd_beat;
            st_d.cap_up   = !(hit_c[0] | hit_u[0]);
            st_d.cap_syn  = st_d.cap_up ? l_syn[1] : l_syn[0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.en   <= EN_KEY;
        end else begin
            st_q <= st_d;
        end
    end

    flash_ce_tracker #(.CNT_W(CNT_W)) u_trk (
        .clk       (clk),
        .rst_n     (rst_n),
        .hits      (hit_c),
        .thr_we    (thr_we),
        .thr_wdata (cfg_wdata),
        .clr_cnt   (clr_cnt),
        .clr_irq   (clr_irq),
        .count     (ce_count),
        .irq       (ce_irq)
    );

    assign out_valid = st_q.vld;
    assign out_data  = st_q.data;
    assign fatal_err = st_q.fatal;
    assign cap_valid = st_q.cap_v;
    assign cap_beat  = st_q.cap_beat;
    assign cap_upper = st_q.cap_up;
    assign cap_syn   = st_q.cap_syn;

    AST_DBG_RAW: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && rd_debug) |=> (out_valid && !fatal_err && out_data == $past(rd_data))); // R8
    AST_OFF_RAW: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && st_q.en != EN_KEY) |=> (!fatal_err && out_data == $past(rd_data))); // R7
    AST_FATAL_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        fatal_err |-> out_valid); // R4
    AST_CAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_valid && !clr_cap) |=> (cap_valid && $stable(cap_beat) && $stable(cap_upper)
                                     && $stable(cap_syn))); // R11

endmodule

// File: tb/tb_flash_rd_secded.sv
module tb_flash_rd_secded;
    import flash_ecc_pkg::*;

    localparam int BAW = 20;
    localparam int CW  = 8;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           rd_valid = 1'b0, rd_debug = 1'b0;
    logic [BAW-1:0] rd_beat = '0;
    logic [127:0]   rd_data = '0;
    logic [15:0]    rd_chk = '0;
    logic           cfg_we = 1'b0;
    logic [1:0]     cfg_sel = '0;
    logic [CW-1:0]  cfg_wdata = '0;
    logic           out_valid, fatal_err, ce_irq, cap_valid, cap_upper;
    logic [127:0]   out_data;
    logic [CW-1:0]  ce_count;
    logic [BAW-1:0] cap_beat;
    logic [7:0]     cap_syn;

    always #4 clk = ~clk;

    flash_rd_secded #(.BEAT_AW(BAW), .CNT_W(CW)) dut (
        .clk(clk), .rst_n(rst_n), .rd_valid(rd_valid), .rd_debug(rd_debug),
        .rd_beat(rd_beat), .rd_data(rd_data), .rd_chk(rd_chk), .cfg_we(cfg_we),
        .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .out_valid(out_valid),
        .out_data(out_data), .fatal_err(fatal_err), .ce_irq(ce_irq),
        .ce_count(ce_count), .cap_valid(cap_valid), .cap_beat(cap_beat),
        .cap_upper(cap_upper), .cap_syn(cap_syn));

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;

    // reference model state
    logic [3:0]     m_en = 4'hA;
    int             m_cnt = 0, m_thr = 1;
    bit             m_irq = 0, m_capv = 0, m_capup = 0, m_vld = 0, m_fatal = 0;
    logic [BAW-1:0] m_capbeat = '0;
    logic [7:0]     m_capsyn = '0;
    logic [127:0]   m_data = '0;

    // per-lane stimulus: 0 clean, 1 single, 2 double, 3 address, 4 skip
    int          ln_kind [2];
    logic [63:0] ln_good [2];
    logic [71:0] ln_raw  [2];
    logic [7:0]  ln_syn  [2];

    function automatic int bpos(input int j);
        int n = 0;
        for (int q = 3; q < 72; q++) begin
            if ($countones(q) != 1) begin
                if (n == j) return q;
                n++;
            end
        end
        return 0;
    endfunction

    function automatic logic [6:0] bit_syn(input int a);
        if (a < 64) return 7'(bpos(a));
        if (a < 71) return 7'(1 << (a - 64));
        return 7'd0;
    endfunction

    task automatic build(input int l, input logic [BAW-1:0] beat, input int kind,
                         input int a, input int b);
        logic [BAW:0] wa;
        logic [63:0]  d;
        logic [71:0]  cw;
        wa = {beat, (l == 1)};
        d  = {$urandom, $urandom};
        ln_kind[l] = kind;
        ln_good[l] = d;
        ln_syn[l]  = 8'd0;
        cw = {ecc_encode(d, 32'(wa)), d};
        case (kind)
            1: begin cw[a] = ~cw[a]; ln_syn[l] = {1'b1, bit_syn(a)}; end
            2: begin
                cw[a] = ~cw[a]; cw[b] = ~cw[b];
                ln_syn[l] = {1'b0, bit_syn(a) ^ bit_syn(b)};
            end
            3: begin
                cw = {ecc_encode(d, 32'(wa ^ ((BAW+1)'(1) << a))), d};
                ln_syn[l] = {1'b0, 7'(bpos(a) ^ bpos(a + 32))};
            end
            4: cw = (a != 0) ? '1 : '0;
            default: ;
        endcase
        ln_raw[l] = cw;
    endtask

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic compare(input string tag);
        vectors++;
        chk(out_valid === m_vld, tag, "out_valid", 128'(out_valid), 128'(m_vld));
        if (m_vld) chk(out_data === m_data, tag, "out_data", out_data, m_data);
        chk(fatal_err === m_fatal, tag, "fatal_err", 128'(fatal_err), 128'(m_fatal));
        chk(ce_count === CW'(m_cnt), "R9", "ce_count", 128'(ce_count), 128'(m_cnt));
        chk(ce_irq === m_irq, "R10", "ce_irq", 128'(ce_irq), 128'(m_irq));
        chk(cap_valid === m_capv, "R11", "cap_valid", 128'(cap_valid), 128'(m_capv));
        if (m_capv) begin
            chk(cap_beat === m_capbeat, "R11", "cap_beat", 128'(cap_beat), 128'(m_capbeat));
            chk(cap_upper === m_capup, "R11", "cap_upper", 128'(cap_upper), 128'(m_capup));
            chk(cap_syn === m_capsyn, "R11", "cap_syn", 128'(cap_syn), 128'(m_capsyn));
        end
    endtask

    // one clock: inputs already set at a falling edge; model advances with the DUT
    task automatic step(input string tag);
        bit           on, clr;
        bit [1:0]     ce, ue;
        logic [127:0] nd;
        int           n_cnt, n_thr;
        bit           n_irq, n_capv, n_capup;
        logic [3:0]   n_en;
        logic [BAW-1:0] n_capbeat;
        logic [7:0]   n_capsyn;
        rd_data = {ln_raw[1][63:0], ln_raw[0][63:0]};
        rd_chk  = {ln_raw[1][71:64], ln_raw[0][71:64]};
        on = rd_valid && !rd_debug && (m_en == 4'hA);
        ce = '0; ue = '0; nd = rd_data;
        for (int l = 0; l < 2; l++) begin
            if (on) begin
                if (ln_kind[l] == 1) begin ce[l] = 1'b1; nd[l*64 +: 64] = ln_good[l]; end
                if (ln_kind[l] == 2 || ln_kind[l] == 3) ue[l] = 1'b1;
            end
        end
        clr   = cfg_we && cfg_sel == 2'd2;
        n_en  = (cfg_we && cfg_sel == 2'd0) ? cfg_wdata[3:0] : m_en;
        n_thr = (cfg_we && cfg_sel == 2'd1) ? ((cfg_wdata == 0) ? 1 : int'(cfg_wdata)) : m_thr;
        n_cnt = (clr && cfg_wdata[2]) ? 0 : m_cnt;
        n_cnt = n_cnt + int'(ce[0]) + int'(ce[1]);
        if (n_cnt > 255) n_cnt = 255;
        n_irq = m_irq && !(clr && cfg_wdata[0]);
        if (ce != 0 && n_cnt >= m_thr) n_irq = 1'b1;
        n_capv = m_capv && !(clr && cfg_wdata[1]);
        n_capup = m_capup; n_capbeat = m_capbeat; n_capsyn = m_capsyn;
        if (!n_capv && (ce | ue) != 0) begin
            n_capv    = 1'b1;
            n_capup   = !(ce[0] | ue[0]);
            n_capbeat = rd_beat;
            n_capsyn  = ln_syn[n_capup ? 1 : 0];
        end
        @(posedge clk);
        #1;
        m_vld = rd_valid;
        if (rd_valid) m_data = nd;
        m_fatal = |ue;
        m_en = n_en; m_thr = n_thr; m_cnt = n_cnt; m_irq = n_irq;
        m_capv = n_capv; m_capup = n_capup; m_capbeat = n_capbeat; m_capsyn = n_capsyn;
        @(negedge clk);
        compare(tag);
        rd_valid = 1'b0; rd_debug = 1'b0; cfg_we = 1'b0;
    endtask

    task automatic beat(input logic [BAW-1:0] bt, input int kl, input int al, input int bl,
                        input int kh, input int ah, input int bh, input bit dbg,
                        input string tag);
        build(0, bt, kl, al, bl);
        build(1, bt, kh, ah, bh);
        rd_valid = 1'b1; rd_debug = dbg; rd_beat = bt;
        step(tag);
    endtask

    task automatic cfg(input logic [1:0] sel, input logic [CW-1:0] val, input string tag);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
        step(tag);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL R1 watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        ln_kind[0] = 0; ln_kind[1] = 0;
        ln_raw[0] = '0; ln_raw[1] = '0;
        ln_good[0] = '0; ln_good[1] = '0;
        ln_syn[0] = '0; ln_syn[1] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        compare("R1");

        // R2: clean codewords at several addresses
        beat(20'h00000, 0, 0, 0, 0, 0, 0, 0, "R2");
        beat(20'h12345, 0, 0, 0, 0, 0, 0, 0, "R2");
        beat(20'hFFFFF, 0, 0, 0, 0, 0, 0, 0, "R2");
        cfg(2'd0, 8'h0, "R12");
        step("R1");

        // R3: single flips in data, check bits and overall parity, both lanes
        cfg(2'd0, 8'hA, "R12");
        beat(20'h00010, 1, 0, 0, 0, 0, 0, 0, "R3");
        beat(20'h00011, 1, 37, 0, 1, 63, 0, 0, "R3");
        beat(20'h00012, 0, 0, 0, 1, 64, 0, 0, "R3");
        beat(20'h00013, 1, 70, 0, 1, 71, 0, 0, "R3");
        cfg(2'd2, 8'h07, "R12");

        // R4: double flips
        beat(20'h00020, 2, 3, 40, 0, 0, 0, 0, "R4");
        beat(20'h00021, 0, 0, 0, 2, 64, 10, 0, "R4");
        beat(20'h00022, 2, 71, 5, 2, 65, 66, 0, "R4");
        cfg(2'd2, 8'h02, "R11");

        // R5: one wrong address bit
        beat(20'h00030, 3, 0, 0, 0, 0, 0, 0, "R5");
        beat(20'h00031, 0, 0, 0, 3, 7, 0, 0, "R5");
        beat(20'h00032, 3, 20, 0, 3, 1, 0, 0, "R5");
        cfg(2'd2, 8'h02, "R11");

        // R6: erased and all-zero words are skipped
        beat(20'h00040, 4, 1, 0, 4, 0, 0, 0, "R6");
        beat(20'h00041, 4, 0, 0, 4, 1, 0, 0, "R6");

        // R8: debug reads pass raw
        beat(20'h00050, 1, 12, 0, 2, 1, 2, 1, "R8");
        // R7: wrong key disables checking
        cfg(2'd0, 8'h5, "R7");
        beat(20'h00051, 1, 12, 0, 3, 2, 0, 0, "R7");
        cfg(2'd0, 8'hA, "R7");
        beat(20'h00052, 1, 12, 0, 0, 0, 0, 0, "R7");

        // R10: threshold behaviour
        cfg(2'd2, 8'h07, "R10");
        cfg(2'd1, 8'h0, "R10");
        beat(20'h00060, 1, 5, 0, 0, 0, 0, 0, "R10");
        cfg(2'd1, 8'h4, "R10");
        cfg(2'd2, 8'h07, "R10");
        for (int i = 0; i < 3; i++) beat(20'h00061, 1, i, 0, 0, 0, 0, 0, "R10");
        step("R10");
        beat(20'h00062, 0, 0, 0, 1, 9, 0, 0, "R10");
        cfg(2'd2, 8'h01, "R10");
        step("R10");

        // R11: lane priority, clear with simultaneous new event
        cfg(2'd2, 8'h02, "R11");
        beat(20'h00070, 1, 30, 0, 2, 4, 50, 0, "R11");
        build(0, 20'h00071, 0, 0, 0);
        build(1, 20'h00071, 1, 44, 0);
        rd_valid = 1'b1; rd_beat = 20'h00071;
        cfg_we = 1'b1; cfg_sel = 2'd2; cfg_wdata = 8'h02;
        step("R11");

        // R9: two events per beat, saturation, clear
        cfg(2'd2, 8'h04, "R9");
        beat(20'h00080, 1, 1, 0, 1, 2, 0, 0, "R9");
        for (int i = 0; i < 130; i++) beat(BAW'(i), 1, i % 72, 0, 1, (i + 7) % 72, 0, 0, "R9");
        beat(20'h00081, 1, 3, 0, 0, 0, 0, 0, "R9");
        cfg(2'd2, 8'h04, "R9");
        beat(20'h00082, 1, 3, 0, 1, 4, 0, 0, "R9");

        repeat (2) step("R1");
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule